// File: doc/BRIEF.md
# Software Watchdog Timer with Prescaler

This block watches for a sign of life from software. It counts clock cycles through an optional fixed prescaler and then through a main counter whose terminal count comes from a two-bit period selector. Software keeps the count from expiring by writing a two-value service sequence to a service register. If the count reaches its terminal value first, the block drives a reset request high for one clock and then starts counting again from zero.

A small register interface has two addresses. The control register holds an enable bit, a prescale-enable bit and the period selector. The service register takes the key values. A mode strap input sets the reset value of the prescale bit. A new period selection is held as pending. It replaces the active period only when a service sequence completes, so a half-done reconfiguration cannot shorten the window that is already running.

With the default parameters the prescaler divides by 512 and the four periods are 2^9, 2^11, 2^13 and 2^15 counts. All of these values are parameters: `PRE_LOG2`, `BASE_LOG2` and `STEP_LOG2`.

Top module: `swdog_top`

## Requirements
- R1: While `rst_n` is low, `ctrl_rdata` reads enable = 1, period select = 00, and prescale-enable = the inverse of `mode_strap`. A strap of 0 selects prescaling and a strap of 1 selects none.
- R2: A write of 0x55 followed by a write of 0xAA to the service register (`reg_addr` = 1) is a completed service. At the edge of the 0xAA write it clears the prescaler and the main counter, so the next request comes exactly one full period after that edge.
- R3: Other bus writes may occur between the two key writes, including control writes and other service values, without breaking the sequence. A service value other than 0x55 or 0xAA leaves the sequence state unchanged. A repeated 0x55 keeps the sequence armed. A 0xAA that is not preceded by an arming write is ignored.
- R4: With prescaling off, period select s gives a timeout of 2^(BASE_LOG2 + STEP_LOG2*s) clocks. `wdt_rst_req` is high in the cycle after that many rising edges have passed since the counter was cleared.
- R5: With prescale-enable = 1, each period is multiplied by 2^PRE_LOG2 (512 by default).
- R6: `wdt_rst_req` is high for exactly one clock. Counting then restarts from zero, so without service a further request follows one period later.
- R7: While enable = 0, the prescaler and counter are held at zero and no request is raised. After enable is written back to 1, a full period elapses from that write before the next request.
- R8: A written period select is only pending. The previous period stays in force until the next completed service, and the new period is used from that point on.
- R9: Software may change prescale-enable at any time after reset.
- R10: Control register (`reg_addr` = 0) bit layout: bit 0 = enable, bit 1 = prescale-enable, bits 3:2 = period select. `ctrl_rdata` returns the written value in the same layout from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 1 | Clock-mode strap; sets the prescale-enable reset value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = service register |
| reg_wdata | input | 8 | Write data |
| ctrl_rdata | output | 4 | Control register contents |
| wdt_rst_req | output | 1 | One-clock timeout reset request |

## Verification
On every cycle the assertions check the following:
- a request pulse never lasts more than one clock;
- disabling forces the counter to zero and suppresses the request;
- a completed service clears the counter and blocks a request on the next edge;
- the armed state changes only on the matching key write;
- the active period changes only after a completed service.

Only the bench's scenarios can show the exact length of each of the eight periods, the reset values that follow the strap, and the way pending period selections and interleaved bus writes behave over a whole timeout window.

// File: rtl/swdog_pkg.sv
// Package: shared constants and types for the software watchdog.
// Assumes an 8-bit write data path and a 4-bit control register.
package swdog_pkg;

    localparam logic [7:0] SVC_KEY_ARM  = 8'h55;
    localparam logic [7:0] SVC_KEY_FIRE = 8'hAA;

    localparam logic REG_CTRL = 1'b0;
    localparam logic REG_SVC  = 1'b1;

    // Control register layout, MSB first: sel[1:0], pre_en, en
    typedef struct packed {
        logic [1:0] sel;
        logic       pre_en;
        logic       en;
    } swdog_ctrl_t;

endpackage

// File: rtl/swdog_svc_seq.sv
// Service sequence checker: arms on the first key and reports a completed
// service when the second key follows. Assumes that the write strobe is
// already qualified with the service register address.
module swdog_svc_seq
    import swdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc_wr,
    input  logic [7:0] svc_wdata,
    output logic       armed,
    output logic       svc_done
);

    logic hit_arm;
    logic hit_fire;

    // Decode the two key values
    always_comb begin
        hit_arm  = svc_wr && (svc_wdata == SVC_KEY_ARM);
        hit_fire = svc_wr && (svc_wdata == SVC_KEY_FIRE);
    end

    // A completed service is the second key arriving while armed
    assign svc_done = hit_fire && armed;

    // Armed state: set by the first key, cleared by a completed service
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (hit_arm) begin
            armed <= 1'b1;
        end else if (svc_done) begin
            armed <= 1'b0;
        end
    end

endmodule

// File: rtl/swdog_regs.sv
// Control register with a pending period select and an active copy that is
// updated only by a completed service. Assumes that the write strobe is
// already qualified with the control register address.
module swdog_regs
    import swdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_strap,
    input  logic        ctrl_wr,
    input  logic [3:0]  ctrl_wdata,
    input  logic        svc_done,
    output swdog_ctrl_t ctrl_q,
    output logic [1:0]  sel_act
);

    // Control register: reset values follow the strap, writes replace all fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.en     <= 1'b1;
            ctrl_q.pre_en <= ~mode_strap;
            ctrl_q.sel    <= 2'b00;
        end else if (ctrl_wr) begin
            ctrl_q <= swdog_ctrl_t'(ctrl_wdata);
        end
    end

    // Active period select: copies the pending select on a completed service
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_act <= 2'b00;
        end else if (svc_done) begin
            sel_act <= ctrl_q.sel;
        end
    end

endmodule

// File: rtl/swdog_prescaler.sv
// Fixed power-of-two prescaler. When bypassed it ticks on every enabled
// cycle. Assumes PRE_LOG2 >= 1.
module swdog_prescaler #(
    parameter int PRE_LOG2 = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bypass,
    input  logic clear,
    output logic tick
);

    logic [PRE_LOG2-1:0] pre_cnt;

    // Tick on terminal prescale count, or on every cycle when bypassed
    assign tick = en && (bypass || (pre_cnt == {PRE_LOG2{1'b1}}));

    // Prescale counter: held at zero while disabled, bypassed or cleared
    always_ff @(posedge clk) begin
        if (!rst_n || !en || bypass || clear) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/swdog_counter.sv
// Main timeout counter with four selectable power-of-two terminal counts.
// Raises a registered one-cycle timeout on the terminal count and restarts
// from zero. A clear has priority over the terminal count.
module swdog_counter #(
    parameter int BASE_LOG2 = 9,
    parameter int STEP_LOG2 = 2,
    parameter int CNT_W     = BASE_LOG2 + 3 * STEP_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic             tick,
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] cnt,
    output logic             timeout
);

    logic [CNT_W-1:0] lim [4];
    logic             at_limit;

    // One terminal value per period select
    for (genvar g = 0; g < 4; g++) begin : g_lim
        localparam int SHIFT = BASE_LOG2 + STEP_LOG2 * g;
        assign lim[g] = CNT_W'((64'd1 << SHIFT) - 64'd1);
    end

    // Terminal count reached on a tick
    assign at_limit = en && tick && (cnt == lim[sel]);

    // Counter: zero on clear, disable or terminal count, else advance on tick
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clear || at_limit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Timeout pulse: one clock after the terminal edge, suppressed by service
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout <= 1'b0;
        end else begin
            timeout <= at_limit && !clear;
        end
    end

endmodule

// File: rtl/swdog_top.sv
// Software watchdog top: register decode, service sequence, prescaler and
// main counter. Assumes one write per cycle through a two-address register
// port. Period values are set by BASE_LOG2, STEP_LOG2 and PRE_LOG2.
module swdog_top
    import swdog_pkg::*;
#(
    parameter int PRE_LOG2  = 9,
    parameter int BASE_LOG2 = 9,
    parameter int STEP_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_strap,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [3:0] ctrl_rdata,
    output logic       wdt_rst_req
);

    localparam int CNT_W = BASE_LOG2 + 3 * STEP_LOG2;

    logic             wr_ctrl;
    logic             wr_svc;
    logic             svc_armed;
    logic             svc_done;
    swdog_ctrl_t      ctrl_q;
    logic [1:0]       sel_act;
    logic             pre_tick;
    logic [CNT_W-1:0] main_cnt;

    // Address decode of the write strobe
    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign wr_svc  = reg_wr && (reg_addr == REG_SVC);

    swdog_svc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .svc_wr    (wr_svc),
        .svc_wdata (reg_wdata),
        .armed     (svc_armed),
        .svc_done  (svc_done)
    );

    swdog_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_strap (mode_strap),
        .ctrl_wr    (wr_ctrl),
        .ctrl_wdata (reg_wdata[3:0]),
        .svc_done   (svc_done),
        .ctrl_q     (ctrl_q),
        .sel_act    (sel_act)
    );

    swdog_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl_q.en),
        .bypass (!ctrl_q.pre_en),
        .clear  (svc_done),
        .tick   (pre_tick)
    );

    swdog_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_q.en),
        .clear   (svc_done),
        .tick    (pre_tick),
        .sel     (sel_act),
        .cnt     (main_cnt),
        .timeout (wdt_rst_req)
    );

    // Control register readback
    assign ctrl_rdata = ctrl_q;

endmodule

// File: rtl/swdog_checker.sv
// Checker for swdog_top, attached with bind. It observes the ports and a few
// internal nets that are driven by separate submodules.
module swdog_checker
    import swdog_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic [3:0] ctrl_rdata,
    input logic       wdt_rst_req,
    input logic       svc_armed,
    input logic       svc_done,
    input logic       cnt_zero,
    input logic [1:0] sel_act
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wdt_rst_req |=> !wdt_rst_req); // R6
    AST_DISABLED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_rdata[0] |=> !wdt_rst_req); // R7
    AST_DISABLED_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_rdata[0] |=> cnt_zero); // R7
    AST_SERVICE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) svc_done |=> !wdt_rst_req); // R2
    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) svc_done |=> cnt_zero); // R2
    AST_ARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(svc_armed) |-> $past(reg_wr && reg_addr == REG_SVC && reg_wdata == SVC_KEY_ARM)); // R3
    AST_DISARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(svc_armed) |-> $past(reg_wr && reg_addr == REG_SVC && reg_wdata == SVC_KEY_FIRE)); // R3
    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(svc_done) |-> $stable(sel_act)); // R8

endmodule

bind swdog_top swdog_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .ctrl_rdata  (ctrl_rdata),
    .wdt_rst_req (wdt_rst_req),
    .svc_armed   (svc_armed),
    .svc_done    (svc_done),
    .cnt_zero    (main_cnt == '0),
    .sel_act     (sel_act)
);

// File: tb/swdog_top_tb_top.sv
// Bench for swdog_top with reduced parameters: prescale x8, periods 16, 64,
// 256 and 1024 clocks. All activity is aligned to falling edges.
module swdog_top_tb_top;

    localparam int PRE_LOG2  = 3;
    localparam int BASE_LOG2 = 4;
    localparam int STEP_LOG2 = 2;

    typedef struct packed {
        logic        pre;
        logic [1:0]  sel;
        logic [31:0] cycles;
    } vec_t;

    // Period table (R4, R5, R9): prescale-enable, select, expected clocks
    localparam vec_t VEC [8] = '{
        '{1'b0, 2'd0, 32'd16},
        '{1'b0, 2'd1, 32'd64},
        '{1'b0, 2'd2, 32'd256},
        '{1'b0, 2'd3, 32'd1024},
        '{1'b1, 2'd0, 32'd128},
        '{1'b1, 2'd1, 32'd512},
        '{1'b1, 2'd3, 32'd8192},
        '{1'b1, 2'd2, 32'd2048}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_strap = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [3:0] ctrl_rdata;
    logic       wdt_rst_req;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    swdog_top #(
        .PRE_LOG2  (PRE_LOG2),
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_strap  (mode_strap),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .ctrl_rdata  (ctrl_rdata),
        .wdt_rst_req (wdt_rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One register write; starts and returns at a falling edge
    task automatic wr(input logic addr, input logic [7:0] data);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic service();
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
    endtask

    // Checks: no pulse before edge n, pulse after edge n, low after edge n+1
    task automatic expect_period(input string req, input int n);
        int early = 0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst_req) early++;
        end
        check(req, early, 0);
        @(negedge clk);
        check(req, wdt_rst_req, 1);
        @(negedge clk);
        check(req, wdt_rst_req, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: reset with strap = 1, so no prescaling
        repeat (3) @(negedge clk);
        check("R1", ctrl_rdata, 4'b0001);
        check("R1", wdt_rst_req, 0);
        rst_n = 1'b1;
        expect_period("R4", 16);
        // R6: next pulse one period after the first
        repeat (14) @(negedge clk);
        check("R6", wdt_rst_req, 0);
        @(negedge clk);
        check("R6", wdt_rst_req, 1);

        // R10: control layout readback
        wr(1'b0, 8'h0D);
        check("R10", ctrl_rdata, 4'hD);
        wr(1'b0, 8'h01);
        check("R10", ctrl_rdata, 4'h1);

        // R8: pending select waits for a completed service
        service();
        wr(1'b0, 8'h09);
        repeat (14) @(negedge clk);
        check("R8", wdt_rst_req, 0);
        @(negedge clk);
        check("R8", wdt_rst_req, 1);
        service();
        expect_period("R8", 256);

        // R3: interleaved writes keep the sequence intact
        wr(1'b0, 8'h01);
        service();
        wr(1'b1, 8'h55);
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h12);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
        expect_period("R3", 16);
        // R3: an unarmed 0xAA is ignored
        service();
        wr(1'b1, 8'hAA);
        repeat (14) @(negedge clk);
        check("R3", wdt_rst_req, 0);
        @(negedge clk);
        check("R3", wdt_rst_req, 1);
        // R3: a non-key value between the keys keeps the sequence armed
        service();
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'hAA);
        expect_period("R3", 16);

        // R4, R5, R9: walk the period table
        for (int k = 0; k < 8; k++) begin
            wr(1'b0, {4'b0, VEC[k].sel, VEC[k].pre, 1'b1});
            check("R9", ctrl_rdata, {VEC[k].sel, VEC[k].pre, 1'b1});
            service();
            expect_period(VEC[k].pre ? "R5" : "R4", int'(VEC[k].cycles));
        end

        // R7: disabled means no pulse; re-enabling restarts a full period
        wr(1'b0, 8'h00);
        check("R7", ctrl_rdata, 4'h0);
        begin
            int seen = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (wdt_rst_req) seen++;
            end
            check("R7", seen, 0);
        end
        wr(1'b0, 8'h01);
        expect_period("R7", 256);

        // R1 and R5: reset with strap = 0 turns prescaling on
        rst_n = 1'b0;
        mode_strap = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", ctrl_rdata, 4'b0011);
        rst_n = 1'b1;
        expect_period("R5", 128);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule